// File: doc/BRIEF.md
# Internal-Clock Conversion Sequencer with Bus Stretching

This block controls the conversions that a read-addressed serial-bus transfer starts when the converter runs from its own internal clock. It receives one-cycle event pulses for START conditions and for rising and falling edges of the bus clock, along with a flag from the address decoder. It counts the bits of the address byte. When the eighth rising edge of a matching read address arrives, it raises a tracking enable. On the falling edge of the ninth bus clock, the acknowledge slot, it begins acquisition. From that point until the whole scan is finished it holds the bus clock low.

While it holds the bus, the block runs the converter stub through every entry of the scan list. The list is supplied by a separate sequencer that is indexed by this block. Each result is written into the next result-memory slot as soon as the converter reports done. After the last result is stored, the block releases the bus clock and raises a power-down request. It does not wait for a STOP. A watchdog counter, counted in system-clock cycles, limits how long each single conversion may keep the bus stretched.

A one-bit mode register selects internal or external conversion clock. In external mode the block never stretches the bus. For a matching address it only pulses a handoff to the external-clock path.

Top module: `stretch_conv_ctrl`

## Requirements
- R1: After reset, sclHold, trackEn, convStart, memWe, pwrDownReq, timeoutErr, extHandoff and extMode are all 0. extMode 0 means internal clock mode.
- R2: In internal mode, trackEn is high from the cycle after the 8th sclRise event that follows startCond, provided addrMatch is high at that event. If addrMatch is low, trackEn stays low and no stretching follows.
- R3: With trackEn high, the sclFall event after the 9th sclRise makes trackEn low, sclHold high and convStart a one-cycle pulse, all in the next cycle.
- R4: sclHold stays high across the entire scan. Each convDone produces, in the next cycle, a one-cycle memWe pulse with memAddr set to the current slot index and memData set to the convData sampled with convDone.
- R5: Slot indices run 0, 1, 2 and so on. seqIdx equals the current slot. If convDone arrives while seqLast is low, the next cycle shows seqIdx incremented and a new convStart pulse.
- R6: A convDone that arrives while seqLast is high ends the scan. In the same cycle as the final memWe, sclHold is low and pwrDownReq is high. pwrDownReq stays high until the next startCond.
- R7: If convDone comes at most STRETCH_LIMIT cycles after the edge that raised convStart, timeoutErr stays 0. If it comes later, timeoutErr goes to 1 and stays there until the next startCond.
- R8: cfgLoad stores cfgExtClk into extMode. With extMode at 1, a matching address produces a one-cycle extHandoff pulse in the cycle after the 8th sclRise. trackEn and sclHold then stay low through the acknowledge slot.
- R9: A startCond event clears pwrDownReq and timeoutErr in the next cycle and restarts the bit count. A new transfer restarts the slot index at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| startCond | input | 1 | Pulse: START or repeated START seen on the bus |
| sclRise | input | 1 | Pulse: rising edge of bus clock |
| sclFall | input | 1 | Pulse: falling edge of bus clock |
| addrMatch | input | 1 | Address byte matches and requests a read |
| cfgLoad | input | 1 | Strobe to load the clock-mode bit |
| cfgExtClk | input | 1 | Clock-mode value to load (1 = external) |
| seqLast | input | 1 | Sequencer: current slot is the final scan entry |
| convDone | input | 1 | Converter stub: conversion finished |
| convData | input | RES_W | Converter stub: result word |
| trackEn | output | 1 | Input tracking active |
| sclHold | output | 1 | Drive bus clock low (stretch) |
| convStart | output | 1 | Pulse: acquire and start a conversion |
| seqIdx | output | IDX_W | Current scan slot index for the sequencer |
| memWe | output | 1 | Result memory write strobe |
| memAddr | output | IDX_W | Result memory slot |
| memData | output | RES_W | Result memory write data |
| pwrDownReq | output | 1 | Request automatic power-down |
| timeoutErr | output | 1 | Sticky: a conversion exceeded the stretch limit |
| extMode | output | 1 | Current clock-mode bit |
| extHandoff | output | 1 | Pulse: transfer handed to the external-clock path |

## Verification
Every cycle, the assertions check these relations: the tracking, stretching and power-down phases exclude one another; start pulses and result writes happen only while the bus is held; the power-down request rises together with the last write and with the bus released; a timeout is flagged only during a stretch; and a stretch never begins in external mode. Only the directed scenarios can show the exact edge counting of the address byte, the slot-by-slot data and address sequence, the exact cycle boundary of the stretch limit, and the clearing effects of a new START.

// File: rtl/stretch_conv_pkg.sv
package stretch_conv_pkg;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_TRACK = 2'd1,
    PH_CONV  = 2'd2,
    PH_DONE  = 2'd3
  } phaseT;

  // strobes from control to datapath
  typedef struct packed {
    logic holding;    // bus currently stretched
    logic startConv;  // launch a conversion
    logic resetIdx;   // restart slot index
    logic nextIdx;    // advance slot index
    logic storeRes;   // write the returned result
    logic handoff;    // pass transfer to external-clock path
    logic clrXfer;    // new transfer: clear sticky flags
  } strobeT;

endpackage

// File: rtl/stretch_conv_fsm.sv
module stretch_conv_fsm
  import stretch_conv_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   startCond,
  input  logic   sclRise,
  input  logic   sclFall,
  input  logic   addrMatch,
  input  logic   extMode,
  input  logic   atAddrEnd,
  input  logic   atAckSlot,
  input  logic   convDone,
  input  logic   lastSlot,
  output strobeT st,
  output logic   trackEn,
  output logic   sclHold,
  output logic   pwrDownReq
);

  phaseT phase, phaseNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) phase <= PH_IDLE;
    else       phase <= phaseNext;
  end

  always_comb begin
    phaseNext = phase;
    st        = '0;
    st.holding = (phase == PH_CONV);
    unique case (phase)
      PH_IDLE: begin
        if (startCond) st.clrXfer = 1'b1;
        else if (sclRise && atAddrEnd && addrMatch) begin
          if (extMode) st.handoff = 1'b1;
          else         phaseNext  = PH_TRACK;
        end
      end
      PH_TRACK: begin
        if (startCond) begin
          st.clrXfer = 1'b1;
          phaseNext  = PH_IDLE;
        end else if (sclFall && atAckSlot) begin
          st.startConv = 1'b1;
          st.resetIdx  = 1'b1;
          phaseNext    = PH_CONV;
        end
      end
      PH_CONV: begin
        if (convDone) begin
          st.storeRes = 1'b1;
          if (lastSlot) phaseNext = PH_DONE;
          else begin
            st.startConv = 1'b1;
            st.nextIdx   = 1'b1;
          end
        end
      end
      PH_DONE: begin
        if (startCond) begin
          st.clrXfer = 1'b1;
          phaseNext  = PH_IDLE;
        end
      end
      default: phaseNext = PH_IDLE;
    endcase
  end

  assign trackEn    = (phase == PH_TRACK);
  assign sclHold    = (phase == PH_CONV);
  assign pwrDownReq = (phase == PH_DONE);

endmodule

// File: rtl/stretch_conv_dp.sv
module stretch_conv_dp
  import stretch_conv_pkg::*;
#(
  parameter int RES_W         = 12,
  parameter int SLOTS         = 12,
  parameter int STRETCH_LIMIT = 1000,
  localparam int IDX_W        = (SLOTS > 1) ? $clog2(SLOTS) : 1,
  localparam int TMR_W        = $clog2(STRETCH_LIMIT + 1)
)(
  input  logic             clk,
  input  logic             rstN,
  input  strobeT           st,
  input  logic             startCond,
  input  logic             sclRise,
  input  logic             cfgLoad,
  input  logic             cfgExtClk,
  input  logic             convDone,
  input  logic [RES_W-1:0] convData,
  output logic             atAddrEnd,
  output logic             atAckSlot,
  output logic             idxAtMax,
  output logic             convStart,
  output logic [IDX_W-1:0] seqIdx,
  output logic             memWe,
  output logic [IDX_W-1:0] memAddr,
  output logic [RES_W-1:0] memData,
  output logic             timeoutErr,
  output logic             extMode,
  output logic             extHandoff
);

  localparam logic [3:0]       BIT_MAX = 4'd15;
  localparam logic [IDX_W-1:0] IDX_TOP = IDX_W'(SLOTS - 1);
  localparam logic [TMR_W-1:0] TMR_TOP = TMR_W'(STRETCH_LIMIT);
  localparam logic [TMR_W-1:0] TMR_HIT = TMR_W'(STRETCH_LIMIT - 1);

  logic [3:0]       bitCnt;
  logic [IDX_W-1:0] idx;
  logic [TMR_W-1:0] stretchTmr;

  // rising-edge count of the current byte window since START
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                          bitCnt <= '0;
    else if (startCond)                 bitCnt <= '0;
    else if (sclRise && bitCnt != BIT_MAX) bitCnt <= bitCnt + 4'd1;
  end

  assign atAddrEnd = (bitCnt == 4'd7);
  assign atAckSlot = (bitCnt == 4'd9);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                          idx <= '0;
    else if (st.resetIdx)               idx <= '0;
    else if (st.nextIdx && idx != IDX_TOP) idx <= idx + 1'b1;
  end

  assign idxAtMax = (idx == IDX_TOP);
  assign seqIdx   = idx;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      convStart  <= 1'b0;
      memWe      <= 1'b0;
      memAddr    <= '0;
      memData    <= '0;
      extHandoff <= 1'b0;
      extMode    <= 1'b0;
    end else begin
      convStart  <= st.startConv;
      memWe      <= st.storeRes;
      extHandoff <= st.handoff;
      if (st.storeRes) begin
        memAddr <= idx;
        memData <= convData;
      end
      if (cfgLoad) extMode <= cfgExtClk;
    end
  end

  // per-conversion stretch watchdog
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stretchTmr <= '0;
      timeoutErr <= 1'b0;
    end else begin
      if (st.startConv)                          stretchTmr <= '0;
      else if (st.holding && stretchTmr != TMR_TOP) stretchTmr <= stretchTmr + 1'b1;
      if (st.clrXfer)                            timeoutErr <= 1'b0;
      else if (st.holding && !convDone && stretchTmr == TMR_HIT) timeoutErr <= 1'b1;
    end
  end

endmodule

// File: rtl/stretch_conv_ctrl.sv
module stretch_conv_ctrl
  import stretch_conv_pkg::*;
#(
  parameter int RES_W         = 12,
  parameter int SLOTS         = 12,
  parameter int STRETCH_LIMIT = 1000,
  localparam int IDX_W        = (SLOTS > 1) ? $clog2(SLOTS) : 1
)(
  input  logic             clk,
  input  logic             rstN,
  input  logic             startCond,
  input  logic             sclRise,
  input  logic             sclFall,
  input  logic             addrMatch,
  input  logic             cfgLoad,
  input  logic             cfgExtClk,
  input  logic             seqLast,
  input  logic             convDone,
  input  logic [RES_W-1:0] convData,
  output logic             trackEn,
  output logic             sclHold,
  output logic             convStart,
  output logic [IDX_W-1:0] seqIdx,
  output logic             memWe,
  output logic [IDX_W-1:0] memAddr,
  output logic [RES_W-1:0] memData,
  output logic             pwrDownReq,
  output logic             timeoutErr,
  output logic             extMode,
  output logic             extHandoff
);

  strobeT st;
  logic   atAddrEnd, atAckSlot, idxAtMax;

  stretch_conv_fsm u_fsm (
    .clk        (clk),
    .rstN       (rstN),
    .startCond  (startCond),
    .sclRise    (sclRise),
    .sclFall    (sclFall),
    .addrMatch  (addrMatch),
    .extMode    (extMode),
    .atAddrEnd  (atAddrEnd),
    .atAckSlot  (atAckSlot),
    .convDone   (convDone),
    .lastSlot   (seqLast | idxAtMax),
    .st         (st),
    .trackEn    (trackEn),
    .sclHold    (sclHold),
    .pwrDownReq (pwrDownReq)
  );

  stretch_conv_dp #(
    .RES_W         (RES_W),
    .SLOTS         (SLOTS),
    .STRETCH_LIMIT (STRETCH_LIMIT)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .st         (st),
    .startCond  (startCond),
    .sclRise    (sclRise),
    .cfgLoad    (cfgLoad),
    .cfgExtClk  (cfgExtClk),
    .convDone   (convDone),
    .convData   (convData),
    .atAddrEnd  (atAddrEnd),
    .atAckSlot  (atAckSlot),
    .idxAtMax   (idxAtMax),
    .convStart  (convStart),
    .seqIdx     (seqIdx),
    .memWe      (memWe),
    .memAddr    (memAddr),
    .memData    (memData),
    .timeoutErr (timeoutErr),
    .extMode    (extMode),
    .extHandoff (extHandoff)
  );

endmodule

// File: rtl/stretch_conv_chk.sv
module stretch_conv_chk (
  input logic clk,
  input logic rstN,
  input logic trackEn,
  input logic sclHold,
  input logic convStart,
  input logic memWe,
  input logic pwrDownReq,
  input logic timeoutErr,
  input logic extMode,
  input logic extHandoff
);

  p_phase_excl_r2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({trackEn, sclHold, pwrDownReq}));

  p_start_in_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    convStart |-> sclHold);

  p_write_in_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> $past(sclHold));

  p_pd_with_last_write_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pwrDownReq) |-> (memWe && !sclHold));

  p_timeout_in_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(timeoutErr) |-> sclHold);

  p_ext_no_stretch_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sclHold) |-> !$past(extMode));

  p_handoff_no_track_r8: assert property (@(posedge clk) disable iff (!rstN)
    extHandoff |-> (!trackEn && !sclHold));

endmodule

bind stretch_conv_ctrl stretch_conv_chk u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .trackEn    (trackEn),
  .sclHold    (sclHold),
  .convStart  (convStart),
  .memWe      (memWe),
  .pwrDownReq (pwrDownReq),
  .timeoutErr (timeoutErr),
  .extMode    (extMode),
  .extHandoff (extHandoff)
);

// File: tb/stretch_conv_ctrl_tb.sv
module stretch_conv_ctrl_tb;

  localparam int CLK_PERIOD = 10;
  localparam int RES_W      = 12;
  localparam int SLOTS      = 12;
  localparam int LIMIT      = 16;
  localparam int IDX_W      = $clog2(SLOTS);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startCond = 0, sclRise = 0, sclFall = 0, addrMatch = 0;
  logic cfgLoad = 0, cfgExtClk = 0, seqLast = 0, convDone = 0;
  logic [RES_W-1:0] convData = '0;
  logic trackEn, sclHold, convStart, memWe, pwrDownReq, timeoutErr, extMode, extHandoff;
  logic [IDX_W-1:0] seqIdx, memAddr;
  logic [RES_W-1:0] memData;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  stretch_conv_ctrl #(.RES_W(RES_W), .SLOTS(SLOTS), .STRETCH_LIMIT(LIMIT)) u_dut (
    .clk(clk), .rstN(rstN), .startCond(startCond), .sclRise(sclRise), .sclFall(sclFall),
    .addrMatch(addrMatch), .cfgLoad(cfgLoad), .cfgExtClk(cfgExtClk), .seqLast(seqLast),
    .convDone(convDone), .convData(convData), .trackEn(trackEn), .sclHold(sclHold),
    .convStart(convStart), .seqIdx(seqIdx), .memWe(memWe), .memAddr(memAddr),
    .memData(memData), .pwrDownReq(pwrDownReq), .timeoutErr(timeoutErr),
    .extMode(extMode), .extHandoff(extHandoff));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic chkEq(input string tag, input int act, input int exp);
    chk(act == exp, tag, act, exp);
  endtask

  // every drive lasts one cycle; outputs are read at the following negedge
  task automatic evStart();
    @(negedge clk) startCond = 1; @(negedge clk) startCond = 0;
  endtask
  task automatic evRise();
    @(negedge clk) sclRise = 1; @(negedge clk) sclRise = 0;
  endtask
  task automatic evFall();
    @(negedge clk) sclFall = 1; @(negedge clk) sclFall = 0;
  endtask

  // START, address byte and acknowledge slot; checks up to the 9th falling edge
  task automatic addrPhase(input bit match, input bit expStretch);
    addrMatch = match;
    evStart();
    chkEq("R9 pwrDownReq after START", pwrDownReq, 0);
    chkEq("R9 timeoutErr after START", timeoutErr, 0);
    for (int b = 1; b <= 8; b++) begin
      evRise();
      if (b < 8) evFall();
    end
    chkEq("R2 trackEn after 8th rise", trackEn, (expStretch) ? 1 : 0);
    evFall();
    evRise();
    chkEq("R2 trackEn after 9th rise", trackEn, (expStretch) ? 1 : 0);
    evFall();
    chkEq("R3 sclHold after 9th fall", sclHold, (expStretch) ? 1 : 0);
    chkEq("R3 convStart after 9th fall", convStart, (expStretch) ? 1 : 0);
    chkEq("R3 trackEn low after 9th fall", trackEn, 0);
    addrMatch = 0;
  endtask

  task automatic tReset();
    chkEq("R1 sclHold", sclHold, 0);
    chkEq("R1 trackEn", trackEn, 0);
    chkEq("R1 convStart", convStart, 0);
    chkEq("R1 memWe", memWe, 0);
    chkEq("R1 pwrDownReq", pwrDownReq, 0);
    chkEq("R1 timeoutErr", timeoutErr, 0);
    chkEq("R1 extHandoff", extHandoff, 0);
    chkEq("R1 extMode internal", extMode, 0);
  endtask

  task automatic tScan(input int n, input int base);
    addrPhase(1'b1, 1'b1);
    chkEq("R9 seqIdx restarts at 0", seqIdx, 0);
    for (int i = 0; i < n; i++) begin
      seqLast = (i == n - 1);
      repeat (3) @(negedge clk);
      chkEq("R4 sclHold during scan", sclHold, 1);
      chkEq("R4 convStart pulse ended", convStart, 0);
      convDone = 1; convData = RES_W'(base + i);
      @(negedge clk) convDone = 0;
      chkEq("R4 memWe pulse", memWe, 1);
      chkEq("R4 memAddr slot", memAddr, i);
      chkEq("R4 memData", memData, base + i);
      if (i == n - 1) begin
        chkEq("R6 sclHold released", sclHold, 0);
        chkEq("R6 pwrDownReq raised", pwrDownReq, 1);
        chkEq("R6 no further convStart", convStart, 0);
      end else begin
        chkEq("R5 next convStart", convStart, 1);
        chkEq("R5 seqIdx advanced", seqIdx, i + 1);
      end
    end
    seqLast = 0;
    repeat (4) @(negedge clk);
    chkEq("R6 pwrDownReq held", pwrDownReq, 1);
    chkEq("R4 memWe one cycle", memWe, 0);
  endtask

  // convDone arrives d cycles after the edge that raised convStart
  task automatic tTimeout(input int d, input bit expErr);
    addrPhase(1'b1, 1'b1);
    seqLast = 1;
    repeat (d - 1) @(negedge clk);
    chkEq("R7 sclHold while waiting", sclHold, 1);
    convDone = 1; convData = 12'h5A5;
    @(negedge clk) convDone = 0;
    seqLast = 0;
    chkEq("R7 timeoutErr", timeoutErr, (expErr) ? 1 : 0);
    repeat (2) @(negedge clk);
    chkEq("R7 timeoutErr sticky", timeoutErr, (expErr) ? 1 : 0);
  endtask

  task automatic tRestart();
    evStart();
    chkEq("R9 pwrDownReq cleared", pwrDownReq, 0);
    chkEq("R9 timeoutErr cleared", timeoutErr, 0);
  endtask

  task automatic tExternal();
    @(negedge clk) begin cfgLoad = 1; cfgExtClk = 1; end
    @(negedge clk) begin cfgLoad = 0; cfgExtClk = 0; end
    chkEq("R8 extMode loaded", extMode, 1);
    addrMatch = 1;
    evStart();
    for (int b = 1; b <= 8; b++) begin
      evRise();
      if (b < 8) evFall();
    end
    chkEq("R8 extHandoff pulse", extHandoff, 1);
    chkEq("R8 no trackEn", trackEn, 0);
    evFall();
    chkEq("R8 extHandoff one cycle", extHandoff, 0);
    evRise();
    evFall();
    chkEq("R8 no sclHold", sclHold, 0);
    chkEq("R8 no convStart", convStart, 0);
    addrMatch = 0;
    @(negedge clk) begin cfgLoad = 1; cfgExtClk = 0; end
    @(negedge clk) cfgLoad = 0;
    chkEq("R8 extMode back to internal", extMode, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    tReset();
    tScan(1, 100);
    tRestart();
    tScan(4, 2000);
    tRestart();
    tTimeout(LIMIT, 1'b0);
    tRestart();
    tTimeout(LIMIT + 1, 1'b1);
    tRestart();
    addrPhase(1'b0, 1'b0);
    chkEq("R2 no pwrDownReq on mismatch", pwrDownReq, 0);
    tExternal();
    tScan(SLOTS, 300);
    tRestart();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule